// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Engine

This block models the read side of a NOR-style flash that can serve both plain asynchronous reads and clocked burst reads. A 16-bit configuration word sets its behaviour. The word is written through a dedicated write strobe and can be read back through the identifier space. It selects:

- asynchronous or synchronous operation;
- the initial latency;
- the polarity and lead time of the WAIT pin;
- the number of clocks each data word is held;
- the active clock edge;
- wrap or no wrap;
- the burst length.

In synchronous mode an address is captured on an active edge. The block then counts the latency and drives WAIT during that time. It then steps through words of a small computed array on the chosen edge. Identifier (non-array) bursts repeat a single word for the whole burst.

The array word at address `a` is `{a[7:0] ^ 8'h5A, a[7:0]}`, with the address zero-extended to 8 bits. The identifier word at offset `o = addr[3:0]` is the configuration word when `o == 5`, and `16'h8900 | o` for every other offset.

Top module: `burst_read_engine`

## Requirements
- R1: After reset the configuration word is 16'hBFCF. This value is read back as the identifier word at offset 5.
- R2: A legal write on a rising clock edge replaces the configuration word. The fields are:
  - bit 15: mode (1 = asynchronous, 0 = synchronous).
  - bits 13:11: latency code L.
  - bit 10: WAIT polarity (1 = active high).
  - bit 9: hold (1 = two edges per word, 0 = one edge).
  - bit 8: WAIT lead (1 = WAIT drops one hold period before the first word).
  - bit 7: linear sequence.
  - bit 6: edge (1 = rising, 0 = falling).
  - bit 3: wrap control (0 = wrap, 1 = no wrap).
  - bits 2:0: length code (001 = 4 words, 010 = 8 words, 011 = 16 words, 111 = continuous).
- R3: A write is ignored and leaves the word unchanged if any of the following holds:
  - bit 14, bit 5 or bit 4 is set;
  - L is below 2;
  - bit 7 is 0;
  - the length code is not 001, 010, 011 or 111.
- R4: In asynchronous mode, `data_out` follows the current `addr` and `id_mode` without a clock. `data_valid` is 1, WAIT stays at its inactive level, and `addr_strobe` has no effect.
- R5: In synchronous mode, an active edge with `addr_strobe` high captures the address and `id_mode`. `data_valid` is 0 and `data_out` is 0 until the L-th active edge after that edge, when the first word appears.
- R6: Each word stays on `data_out` for one active edge, or for two when bit 9 is set.
- R7: A burst of 4, 8 or 16 words ends when its last word has been held for its full time. `data_valid` then returns to 0. A continuous burst never ends by itself.
- R8: With wrap selected on a fixed-length burst of N words, the address runs through the aligned N-word block and wraps back to its start. Without wrap, and in continuous bursts, it increments modulo 2^ADDR_W.
- R9: WAIT is at its active level (the value of bit 10) from the capture edge for L edges, minus the lead. The lead is the hold time when bit 8 is set and zero when it is clear. WAIT is inactive at all other times.
- R10: An identifier burst repeats the identifier word of the captured offset for every word of the burst.
- R11: All burst state changes happen only on the edge selected by bit 6. The outputs are stable across the opposite edge.
- R12: A new `addr_strobe` on an active edge restarts the burst. This holds on the same edge where the current burst would end, and during a continuous burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; configuration writes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| addr_strobe | input | 1 | Address valid, sampled on the active edge |
| addr | input | ADDR_W | Read address or identifier offset |
| id_mode | input | 1 | 1 = identifier read, 0 = array read |
| data_out | output | 16 | Read data |
| data_valid | output | 1 | Data on `data_out` is valid |
| wait_out | output | 1 | WAIT pin, polarity set by bit 10 |

## Verification
Three functions of this block can fall on the same active edge. The end of a burst (the last hold edge of the final word) and a fresh address capture can coincide. So can a continuous burst stepping forward and a restart. The bench provokes the first case by counting active edges from the capture and raising `addr_strobe` exactly on the edge where the burst would end. It provokes the second by raising `addr_strobe` in the middle of a continuous run. The behavioural model gives the capture priority, so a correct design shows a fresh latency period at once, with WAIT active and no extra word. A design that lets the end win would drop out of the burst, and a design that lets the step win would emit another word; either one is reported on the following edge.

// File: rtl/brd_pkg.sv
package brd_pkg;
  localparam int CFG_W = 16;
  localparam logic [CFG_W-1:0] CFG_RESET = 16'hBFCF;
  localparam int B_MODE = 15;
  localparam int B_WPOL = 10;
  localparam int B_EDGE = 6;

  typedef enum logic [1:0] {PH_IDLE, PH_LAT, PH_DATA} phase_t;

  typedef struct packed {
    logic       mode;
    logic       rsv14;
    logic [2:0] lat;
    logic       wpol;
    logic       hold2;
    logic       wlead;
    logic       linear;
    logic       edge_r;
    logic [1:0] rsv54;
    logic       nowrap;
    logic [2:0] blen;
  } cfg_t;

  function automatic logic blen_legal(input logic [2:0] bl);
    return (bl == 3'b001) || (bl == 3'b010) || (bl == 3'b011) || (bl == 3'b111);
  endfunction

  function automatic logic cfg_legal(input logic [CFG_W-1:0] w);
    cfg_t c;
    c = cfg_t'(w);
    return !c.rsv14 && (c.rsv54 == 2'b00) && (c.lat >= 3'd2) && c.linear && blen_legal(c.blen);
  endfunction

  function automatic logic [4:0] burst_words(input logic [2:0] bl);
    case (bl)
      3'b001:  return 5'd4;
      3'b010:  return 5'd8;
      default: return 5'd16;
    endcase
  endfunction

  // number of latency edges during which WAIT is active
  function automatic logic [2:0] wait_len(input logic [2:0] lat, input logic hold2, input logic wlead);
    logic [2:0] lead;
    lead = wlead ? (hold2 ? 3'd2 : 3'd1) : 3'd0;
    return lat - lead;
  endfunction

  function automatic logic [CFG_W-1:0] id_word(input logic [3:0] off, input logic [CFG_W-1:0] cfg);
    return (off == 4'd5) ? cfg : {12'h890, off};
  endfunction
endpackage

// File: rtl/brd_cfg_reg.sv
module brd_cfg_reg import brd_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg_q
);
  logic accept;
  assign accept = we && cfg_legal(wdata);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cfg_q <= CFG_RESET;
    else if (accept) cfg_q <= wdata;

  // R3: reserved fields and latency code never hold an illegal value
  a_r3_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[14] && (cfg_q[5:4] == 2'b00) && (cfg_q[13:11] >= 3'd2) && cfg_q[7]);
  a_r3_illegal_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !cfg_legal(wdata)) |=> $stable(cfg_q));
  // R2: a legal write lands on the next edge
  a_r2_write_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (we && cfg_legal(wdata)) |=> (cfg_q == $past(wdata)));
endmodule

// File: rtl/brd_array.sv
module brd_array #(parameter int ADDR_W = 8) (
  input  logic [ADDR_W-1:0] addr,
  output logic [15:0]       word
);
  logic [7:0] lo;
  generate
    if (ADDR_W >= 8) begin : g_wide
      assign lo = addr[7:0];
    end else begin : g_narrow
      assign lo = {{(8-ADDR_W){1'b0}}, addr};
    end
  endgenerate
  assign word = {lo ^ 8'h5A, lo};
endmodule

// File: rtl/brd_seq.sv
module brd_seq import brd_pkg::*; #(parameter int ADDR_W = 8) (
  input  logic              act_clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              start_id,
  input  logic [2:0]        lat,
  input  logic              hold2,
  input  logic              wlead,
  input  logic              nowrap,
  input  logic [2:0]        blen,
  output logic              valid,
  output logic              wait_act,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              id_burst
);
  phase_t      phase;
  logic [2:0]  lat_cnt;
  logic        hold_ph;
  logic [4:0]  wcnt;
  logic [4:0]  nwords;
  logic        cont, wrap, lat_last, word_adv, burst_end;
  logic [ADDR_W-1:0] mask, nxt;

  assign nwords    = burst_words(blen);
  assign cont      = (blen == 3'b111);
  assign wrap      = !nowrap && !cont;
  assign mask      = ADDR_W'(nwords - 5'd1);
  assign nxt       = wrap ? ((cur_addr & ~mask) | ((cur_addr + ADDR_W'(1)) & mask))
                          : (cur_addr + ADDR_W'(1));
  assign lat_last  = (lat_cnt == (lat - 3'd1));
  assign word_adv  = !hold2 || hold_ph;
  assign burst_end = !cont && (wcnt == (nwords - 5'd1));

  always_ff @(posedge act_clk or negedge rst_n)
    if (!rst_n) begin
      phase <= PH_IDLE; lat_cnt <= '0; hold_ph <= 1'b0;
      wcnt <= '0; cur_addr <= '0; id_burst <= 1'b0;
    end else if (start) begin
      phase <= PH_LAT; lat_cnt <= '0; hold_ph <= 1'b0;
      wcnt <= '0; cur_addr <= start_addr; id_burst <= start_id;
    end else begin
      case (phase)
        PH_LAT:
          if (lat_last) phase <= PH_DATA;
          else          lat_cnt <= lat_cnt + 3'd1;
        PH_DATA:
          if (word_adv) begin
            hold_ph <= 1'b0;
            if (burst_end) phase <= PH_IDLE;
            else begin
              wcnt <= wcnt + 5'd1;
              if (!id_burst) cur_addr <= nxt;
            end
          end else hold_ph <= 1'b1;
        default: ;
      endcase
    end

  assign valid    = (phase == PH_DATA);
  assign wait_act = (phase == PH_LAT) && (lat_cnt < wait_len(lat, hold2, wlead));

  // R12: a capture always opens a fresh latency period
  a_r12_start_clears: assert property (@(posedge act_clk) disable iff (!rst_n)
    start |=> !valid);
  // R7: fixed bursts never count past their length
  a_r7_count_bound: assert property (@(posedge act_clk) disable iff (!rst_n)
    (valid && !cont) |-> (wcnt < nwords));
  // R9: WAIT is never active while a word is driven
  a_r9_no_wait_in_data: assert property (@(posedge act_clk) disable iff (!rst_n)
    valid |-> !wait_act);
endmodule

// File: rtl/burst_read_engine.sv
module burst_read_engine import brd_pkg::*; #(parameter int ADDR_W = 8) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              addr_strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic              id_mode,
  output logic [CFG_W-1:0]  data_out,
  output logic              data_valid,
  output logic              wait_out
);
  logic [CFG_W-1:0]  cfg_q;
  logic              act_clk, async_md, start;
  logic              seq_valid, seq_wait, seq_id;
  logic [ADDR_W-1:0] seq_addr, rd_addr;
  logic              rd_id;
  logic [15:0]       arr_word, rd_word;

  brd_cfg_reg u_cfg (.clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .cfg_q(cfg_q));

  assign act_clk  = cfg_q[B_EDGE] ? clk : ~clk;
  assign async_md = cfg_q[B_MODE];
  assign start    = addr_strobe && !async_md;

  brd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .act_clk(act_clk), .rst_n(rst_n), .start(start), .start_addr(addr), .start_id(id_mode),
    .lat(cfg_q[13:11]), .hold2(cfg_q[9]), .wlead(cfg_q[8]), .nowrap(cfg_q[3]), .blen(cfg_q[2:0]),
    .valid(seq_valid), .wait_act(seq_wait), .cur_addr(seq_addr), .id_burst(seq_id));

  assign rd_addr = async_md ? addr : seq_addr;
  assign rd_id   = async_md ? id_mode : seq_id;

  brd_array #(.ADDR_W(ADDR_W)) u_arr (.addr(rd_addr), .word(arr_word));

  assign rd_word    = rd_id ? id_word(4'(rd_addr), cfg_q) : arr_word;
  assign data_valid = async_md || seq_valid;
  assign data_out   = data_valid ? rd_word : '0;
  assign wait_out   = (seq_wait && !async_md) ? cfg_q[B_WPOL] : !cfg_q[B_WPOL];

  // R9: WAIT sits at its inactive level whenever data is valid
  a_r9_wait_level: assert property (@(posedge act_clk) disable iff (!rst_n)
    data_valid |-> (wait_out == !cfg_q[B_WPOL]));
  // R10: an identifier burst keeps the same word on consecutive valid edges
  a_r10_nonarray_repeats: assert property (@(posedge act_clk) disable iff (!rst_n)
    (seq_valid && seq_id && $past(seq_valid) && !async_md) |-> $stable(data_out));
  // R4: asynchronous mode keeps the output valid and WAIT idle
  a_r4_async_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    async_md |-> (data_valid && (wait_out == !cfg_q[B_WPOL])));
endmodule

// File: tb/burst_read_engine_tb.sv
`timescale 1ns/1ps
module burst_read_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        addr_strobe = 1'b0;
  logic [7:0]  addr = '0;
  logic        id_mode = 1'b0;
  logic [15:0] data_out;
  logic        data_valid, wait_out;

  burst_read_engine #(.ADDR_W(8)) u_dut (.*);

  always #2.5 clk = ~clk;

  int    errors = 0, checks = 0;
  string cur_req = "R1";
  logic [15:0] m_cfg = 16'hBFCF;
  bit    act = 0, sid = 0;
  int    k = 0, sa = 0;
  bit    done = 0;

  function automatic logic [15:0] rom16(input int a);
    logic [7:0] b;
    b = 8'(a);
    return {b ^ 8'h5A, b};
  endfunction
  function automatic logic [15:0] idw(input int off);
    return (off == 5) ? m_cfg : (16'h8900 | 16'(off));
  endfunction
  function automatic bit bench_legal(input logic [15:0] w);
    return ((w & 16'h4030) == 0) && (w[13:11] > 1) && w[7] &&
           (w[2:0] == 1 || w[2:0] == 2 || w[2:0] == 3 || w[2:0] == 7);
  endfunction

  task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic compare();
    int lc, hold, lead, n, j, aj;
    bit ev, ew, cont;
    logic [15:0] ed;
    lc = int'(m_cfg[13:11]);
    hold = m_cfg[9] ? 2 : 1;
    lead = m_cfg[8] ? hold : 0;
    cont = (m_cfg[2:0] == 3'd7);
    n = (m_cfg[2:0] == 1) ? 4 : (m_cfg[2:0] == 2) ? 8 : 16;
    if (m_cfg[15]) begin
      ev = 1; ew = 0; ed = id_mode ? idw(int'(addr[3:0])) : rom16(int'(addr));
    end else if (act && k >= lc) begin
      ev = 1; ew = 0; j = (k - lc) / hold;
      if (!m_cfg[3] && !cont) aj = (sa / n) * n + (sa + j) % n;
      else aj = (sa + j) % 256;
      ed = sid ? idw(sa % 16) : rom16(aj);
    end else begin
      ev = 0; ew = act && (k < lc - lead); ed = 16'h0;
    end
    chk(cur_req, "data_valid", 16'(data_valid), 16'(ev));
    chk(cur_req, "wait_out", 16'(wait_out), 16'(ew ? m_cfg[10] : !m_cfg[10]));
    chk(cur_req, "data_out", data_out, ed);
  endtask

  // one active edge: sample inputs, advance the model, compare, then check stability across the other edge
  task automatic tick();
    bit s, idm; int a, lc, hold, n;
    logic [15:0] d0; logic v0, w0;
    s = addr_strobe; idm = id_mode; a = int'(addr);
    if (m_cfg[6]) @(posedge clk); else @(negedge clk);
    if (!m_cfg[15]) begin
      lc = int'(m_cfg[13:11]); hold = m_cfg[9] ? 2 : 1;
      n = (m_cfg[2:0] == 1) ? 4 : (m_cfg[2:0] == 2) ? 8 : 16;
      if (s) begin act = 1; k = 0; sa = a; sid = idm; end
      else if (act) begin
        k++;
        if (m_cfg[2:0] != 3'd7 && k >= lc && (k - lc) / hold >= n) act = 0;
      end
    end
    #2;
    compare();
    d0 = data_out; v0 = data_valid; w0 = wait_out;
    if (m_cfg[6]) @(negedge clk); else @(posedge clk);
    #1;
    chk("R11", "stable data", data_out, d0);
    chk("R11", "stable valid/wait", {14'h0, data_valid, wait_out}, {14'h0, v0, w0});
  endtask

  task automatic write_cfg(input logic [15:0] w);
    cfg_wdata = w; cfg_we = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    if (bench_legal(w)) m_cfg = w;
  endtask

  task automatic burst(input int a, input bit idm);
    addr = 8'(a); id_mode = idm; addr_strobe = 1'b1;
    tick();
    addr_strobe = 1'b0;
    while (act) tick();
    tick();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    id_mode = 1'b1; addr = 8'd5;
    #21 rst_n = 1'b1;
    #1;
    // R1: reset word read back through identifier offset 5
    chk("R1", "reset cfg readback", data_out, 16'hBFCF);
    chk("R1", "reset valid/wait", {14'h0, data_valid, wait_out}, 16'h0002);

    // R4: asynchronous reads follow addr, strobe does nothing
    cur_req = "R4";
    id_mode = 1'b0; addr = 8'h12; #1;
    chk("R4", "async array word", data_out, 16'h4812);
    addr_strobe = 1'b1; tick(); tick(); addr_strobe = 1'b0;
    addr = 8'h3C; tick();
    id_mode = 1'b1; addr = 8'h07; tick();

    // R2 R5 R8: sync, latency 3, one-edge hold, wrap, 4 words
    cur_req = "R8";
    write_cfg(16'h1CC1);
    burst(8'h0E, 0);

    // R12: capture on the very edge the burst would end
    cur_req = "R12";
    addr = 8'h31; id_mode = 1'b0; addr_strobe = 1'b1; tick(); addr_strobe = 1'b0;
    repeat (6) tick();
    addr = 8'h52; addr_strobe = 1'b1; tick(); addr_strobe = 1'b0;
    chk("R12", "restart valid", 16'(data_valid), 16'h0);
    while (act) tick();
    tick();

    // R3: illegal writes leave the word unchanged (read back via identifier burst)
    cur_req = "R3";
    write_cfg(16'h5CC1); burst(5, 1);
    write_cfg(16'h1CD1); burst(5, 1);
    write_cfg(16'h0CC1); burst(5, 1);
    write_cfg(16'h1C41); burst(5, 1);
    write_cfg(16'h1CC4); burst(5, 1);
    chk("R3", "cfg unchanged", m_cfg, 16'h1CC1);

    // R9 R6: four WAIT polarity / lead combinations, two-edge hold, no wrap
    cur_req = "R9";
    write_cfg(16'h22C9); burst(8'h3E, 0);
    write_cfg(16'h26C9); burst(8'h3E, 0);
    write_cfg(16'h23C9); burst(8'h3E, 0);
    write_cfg(16'h27C9); burst(8'h3E, 0);

    // R7 R8: 8-word wrap at latency 2 with lead
    cur_req = "R7";
    write_cfg(16'h15C2); burst(8'h25, 0);

    // R10: identifier bursts repeat one word
    cur_req = "R10";
    burst(8'h05, 1);
    burst(8'h03, 1);

    // R7 R8: 16 words without wrap across the top of the address space
    cur_req = "R8";
    write_cfg(16'h15CB); burst(8'hF8, 0);

    // R11: falling edge operation
    cur_req = "R11";
    write_cfg(16'h1C81); burst(8'h0E, 0);
    burst(8'h44, 0);

    // R7 R12: continuous burst, then restart mid-stream
    cur_req = "R7";
    write_cfg(16'h15CF);
    addr = 8'h70; id_mode = 1'b0; addr_strobe = 1'b1; tick(); addr_strobe = 1'b0;
    repeat (25) tick();
    chk("R7", "continuous still valid", 16'(data_valid), 16'h1);
    cur_req = "R12";
    addr = 8'hFE; addr_strobe = 1'b1; tick(); addr_strobe = 1'b0;
    repeat (12) tick();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule